// File: doc/BRIEF.md
# CCD Line and Frame Readout Sequencer

This block paces the readout of one full frame from a full-frame CCD. A start request in the idle state opens a sequence of three parts. First a charge-reset interval empties the image area. Next comes an integration interval whose length is taken from a register. Readout follows, one line at a time. Each line begins with a vertical transfer window. In that window four vertical clock phases move the image down by one row while the horizontal register clocks are held stopped. Then the register line is read out pixel by pixel, and every pixel is tagged with its kind: dummy, black reference, timing, or active.

All timing is counted in pixel strobes (`pix_stb`) supplied by the register clock generator. One strobe is one pixel period. When no strobe arrives, the sequencer holds its position. The geometry is set by parameters: pixel group sizes, the vertical slot width, and the black and active line counts. Their defaults give 3127 read pixels plus a 360-period window per line (3487 periods in total) and 2060 lines per frame.

The outputs are plain control levels for the clock drivers and the analog front end: `ssc` runs the horizontal clocks, `a_clk` carries the four vertical phases, `a_high` is the transport boost, `vd` is the frame mark, `blc` is the black clamp and `cr` is the charge reset. Alongside them come a per-pixel tag and the current line number.

Top module: `ccd_readout_seq`

## Requirements
- R1: After reset and while idle, `ssc`, `cr`, `vd`, `blc` and `a_high` are low, `pix_tag` is 0, `line_idx` is 0 and `a_clk` is at the rest code 4'b1100 (phases 2 and 3 high).
- R2: A `start_frame` seen in the idle state raises `cr` from the next cycle for exactly CR_LEN strobes. A `start_frame` seen at any other time has no effect.
- R3: After charge reset, integration lasts exactly `integ_time` strobes, and a value of 0 skips it. During integration `cr`, `a_high` and `ssc` are low. `integ_time` is held stable for the whole frame.
- R4: Each readout line is a vertical window of 8*SLOT strobes with `ssc` low, followed by DUMMY+2*BLACK+2*TIMING+ACTIVE strobes with `ssc` high.
- R5: Within the horizontal part of a line, the pixel tags run in this order: DUMMY tags of code 1 (dummy), BLACK tags of code 2 (black), TIMING tags of code 3 (timing), ACTIVE tags of code 4 (active), TIMING tags of code 3, and BLACK tags of code 2. `pix_tag` is nonzero only in a cycle where `pix_stb` is high during horizontal readout.
- R6: In the vertical window, slot = (strobes elapsed in the window)/SLOT, and `a_clk[k]` is high exactly when (slot - 2k) mod 8 < 5. This keeps two or three phases high at all times. Outside the window `a_clk` is 4'b1100.
- R7: `a_high` is high for the whole readout, from the first window to the last pixel of the last line, and low otherwise.
- R8: `vd` is high throughout line 0 of readout, including its vertical window, and low otherwise.
- R9: `blc` is high at the horizontal positions of the leading black group (tag code 2 right after the dummies), whether or not a strobe is present. It is low at every other time.
- R10: `line_idx` holds the current readout line, from 0 to 2*BLK_LINES+ACT_LINES-1. After the last pixel of the last line the block returns to idle.
- R11: A cycle without `pix_stb` changes no position counter. In such a cycle `ssc`, `a_clk`, `a_high`, `vd`, `blc` and `line_idx` keep their values and `pix_tag` is 0. The only exception is the step from idle into charge reset on `start_frame`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_frame | input | 1 | Frame request, accepted only while idle |
| integ_time | input | INTEG_W | Integration length in pixel strobes |
| pix_stb | input | 1 | One pulse per pixel period from the register clock generator |
| ssc | output | 1 | Horizontal register clocks run when high |
| a_clk | output | 4 | Vertical clock phases, bit k is phase k |
| a_high | output | 1 | Vertical clock high-level boost during readout |
| vd | output | 1 | Frame mark during the first readout line |
| blc | output | 1 | Black level clamp during leading black pixels |
| cr | output | 1 | Charge reset of the image area |
| pix_tag | output | 3 | Pixel kind: 0 none, 1 dummy, 2 black, 3 timing, 4 active |
| line_idx | output | LINE_W | Current readout line |

## Verification
The properties make no assumption about how `pix_stb` is spaced or about when `start_frame` arrives. Strobes may come every cycle or with gaps, and stray start requests may land in any state. The one assumption is that `integ_time` does not change while a frame runs. The stimulus sets it once per frame, to 0, to 1 or to a random value, and leaves it alone until the block is idle again. Strobe gaps and stray start pulses are randomized throughout.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_CLR   = 2'd1,
    SEQ_INTEG = 2'd2,
    SEQ_READ  = 2'd3
  } seq_state_t;

  typedef enum logic [2:0] {
    TAG_NONE   = 3'd0,
    TAG_DUMMY  = 3'd1,
    TAG_BLACK  = 3'd2,
    TAG_TIMING = 3'd3,
    TAG_ACTIVE = 3'd4
  } pix_tag_t;

  // vertical phases parked between windows: phases 2 and 3 high
  localparam logic [3:0] A_REST = 4'b1100;

  localparam int N_SLOTS   = 8;
  localparam int HIGH_SLOT = 5;
  localparam int STEP_SLOT = 2;

endpackage

// File: rtl/ccd_frame_ctrl.sv
module ccd_frame_ctrl
  import ccd_seq_pkg::*;
#(
  parameter int CR_LEN  = 180,
  parameter int INTEG_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_req,
  input  logic               stb,
  input  logic [INTEG_W-1:0] integ_time,
  input  logic               frame_done,
  output seq_state_t         state
);

  localparam logic [INTEG_W-1:0] CR_LAST = INTEG_W'(CR_LEN - 1);

  logic [INTEG_W-1:0] cnt;
  logic [INTEG_W:0]   cnt_next;

  assign cnt_next = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: begin
          cnt <= '0;
          if (start_req) state <= SEQ_CLR;
        end
        SEQ_CLR: if (stb) begin
          if (cnt == CR_LAST) begin
            cnt   <= '0;
            state <= (integ_time == '0) ? SEQ_READ : SEQ_INTEG;
          end else begin
            cnt <= cnt_next[INTEG_W-1:0];
          end
        end
        SEQ_INTEG: if (stb) begin
          if (cnt_next == {1'b0, integ_time}) begin
            cnt   <= '0;
            state <= SEQ_READ;
          end else begin
            cnt <= cnt_next[INTEG_W-1:0];
          end
        end
        SEQ_READ: if (frame_done) state <= SEQ_IDLE;
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer #(
  parameter int VT_LEN   = 360,
  parameter int LINE_LEN = 3487,
  parameter int LINES    = 2060,
  parameter int POS_W    = 12,
  parameter int LINE_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              stb,
  output logic              in_win,
  output logic [POS_W-1:0]  hpos,
  output logic [LINE_W-1:0] line,
  output logic              frame_done
);

  localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(LINE_LEN - 1);
  localparam logic [POS_W-1:0]  WIN_END   = POS_W'(VT_LEN);
  localparam logic [LINE_W-1:0] LINE_LAST = LINE_W'(LINES - 1);

  logic [POS_W-1:0] pos;
  logic             last_pos;
  logic             last_line;

  assign last_pos  = (pos == POS_LAST);
  assign last_line = (line == LINE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      pos  <= '0;
      line <= '0;
    end else if (stb) begin
      if (last_pos) begin
        pos  <= '0;
        line <= last_line ? '0 : line + 1'b1;
      end else begin
        pos <= pos + 1'b1;
      end
    end
  end

  assign in_win     = en && (pos < WIN_END);
  assign hpos       = pos - WIN_END;
  assign frame_done = en && stb && last_pos && last_line;

endmodule

// File: rtl/ccd_vclk_gen.sv
module ccd_vclk_gen
  import ccd_seq_pkg::*;
#(
  parameter int SLOT = 45
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_win,
  input  logic       stb,
  output logic [3:0] a_clk
);

  localparam int TICK_W = (SLOT > 1) ? $clog2(SLOT) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SLOT - 1);

  logic [TICK_W-1:0] tick;
  logic [2:0]        slot;

  always_ff @(posedge clk) begin
    if (!rst_n || !in_win) begin
      tick <= '0;
      slot <= '0;
    end else if (stb) begin
      if (tick == TICK_LAST) begin
        tick <= '0;
        slot <= slot + 1'b1;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_phase
    logic [2:0] rel;
    assign rel      = slot - 3'(STEP_SLOT * k);
    assign a_clk[k] = in_win ? (rel < 3'(HIGH_SLOT)) : A_REST[k];
  end

endmodule

// File: rtl/ccd_pix_tagger.sv
module ccd_pix_tagger
  import ccd_seq_pkg::*;
#(
  parameter int DUMMY  = 7,
  parameter int BLACK  = 20,
  parameter int TIMING = 4,
  parameter int ACTIVE = 3072,
  parameter int POS_W  = 12
) (
  input  logic             hvalid,
  input  logic             stb,
  input  logic [POS_W-1:0] hpos,
  output logic [2:0]       tag,
  output logic             blc
);

  localparam logic [POS_W-1:0] E_DUM  = POS_W'(DUMMY);
  localparam logic [POS_W-1:0] E_BLK  = POS_W'(DUMMY + BLACK);
  localparam logic [POS_W-1:0] E_TIM  = POS_W'(DUMMY + BLACK + TIMING);
  localparam logic [POS_W-1:0] E_ACT  = POS_W'(DUMMY + BLACK + TIMING + ACTIVE);
  localparam logic [POS_W-1:0] E_TIM2 = POS_W'(DUMMY + BLACK + 2*TIMING + ACTIVE);

  pix_tag_t kind;

  always_comb begin
    if (hpos < E_DUM)       kind = TAG_DUMMY;
    else if (hpos < E_BLK)  kind = TAG_BLACK;
    else if (hpos < E_TIM)  kind = TAG_TIMING;
    else if (hpos < E_ACT)  kind = TAG_ACTIVE;
    else if (hpos < E_TIM2) kind = TAG_TIMING;
    else                    kind = TAG_BLACK;
  end

  assign tag = (hvalid && stb) ? kind : TAG_NONE;
  assign blc = hvalid && (hpos >= E_DUM) && (hpos < E_BLK);

endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
  import ccd_seq_pkg::*;
#(
  parameter int DUMMY     = 7,
  parameter int BLACK     = 20,
  parameter int TIMING    = 4,
  parameter int ACTIVE    = 3072,
  parameter int SLOT      = 45,
  parameter int BLK_LINES = 6,
  parameter int ACT_LINES = 2048,
  parameter int CR_LEN    = 180,
  parameter int INTEG_W   = 24,
  localparam int LINES    = 2*BLK_LINES + ACT_LINES,
  localparam int LINE_W   = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_frame,
  input  logic [INTEG_W-1:0] integ_time,
  input  logic               pix_stb,
  output logic               ssc,
  output logic [3:0]         a_clk,
  output logic               a_high,
  output logic               vd,
  output logic               blc,
  output logic               cr,
  output logic [2:0]         pix_tag,
  output logic [LINE_W-1:0]  line_idx
);

  localparam int PIX_PER_LINE = DUMMY + 2*BLACK + 2*TIMING + ACTIVE;
  localparam int VT_LEN       = N_SLOTS * SLOT;
  localparam int LINE_LEN     = VT_LEN + PIX_PER_LINE;
  localparam int POS_W        = $clog2(LINE_LEN);

  seq_state_t       state;
  logic             in_read;
  logic             in_win;
  logic             frame_done;
  logic [POS_W-1:0] hpos;

  ccd_frame_ctrl #(.CR_LEN(CR_LEN), .INTEG_W(INTEG_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_req  (start_frame),
    .stb        (pix_stb),
    .integ_time (integ_time),
    .frame_done (frame_done),
    .state      (state)
  );

  assign in_read = (state == SEQ_READ);

  ccd_line_timer #(
    .VT_LEN(VT_LEN), .LINE_LEN(LINE_LEN), .LINES(LINES),
    .POS_W(POS_W), .LINE_W(LINE_W)
  ) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (in_read),
    .stb        (pix_stb),
    .in_win     (in_win),
    .hpos       (hpos),
    .line       (line_idx),
    .frame_done (frame_done)
  );

  ccd_vclk_gen #(.SLOT(SLOT)) u_vclk (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_win (in_win),
    .stb    (pix_stb),
    .a_clk  (a_clk)
  );

  ccd_pix_tagger #(
    .DUMMY(DUMMY), .BLACK(BLACK), .TIMING(TIMING),
    .ACTIVE(ACTIVE), .POS_W(POS_W)
  ) u_tag (
    .hvalid (in_read && !in_win),
    .stb    (pix_stb),
    .hpos   (hpos),
    .tag    (pix_tag),
    .blc    (blc)
  );

  assign ssc    = in_read && !in_win;
  assign a_high = in_read;
  assign vd     = in_read && (line_idx == '0);
  assign cr     = (state == SEQ_CLR);

endmodule

// File: rtl/ccd_readout_seq_chk.sv
module ccd_readout_seq_chk #(
  parameter int LINE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_stb,
  input logic              ssc,
  input logic [3:0]        a_clk,
  input logic              a_high,
  input logic              vd,
  input logic              blc,
  input logic              cr,
  input logic [2:0]        pix_tag,
  input logic [LINE_W-1:0] line_idx
);

  // R6
  win_phase_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_high && !ssc) |-> ($countones(a_clk) >= 2 && $countones(a_clk) <= 3));

  // R6
  rest_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_high && !ssc) |-> (a_clk == 4'b1100));

  // R11
  hold_without_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_stb |=> ($stable(ssc) && $stable(a_clk) && $stable(a_high) &&
                  $stable(vd) && $stable(line_idx)));

  // R5
  tag_needs_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_tag != 3'd0) |-> (pix_stb && ssc && pix_tag <= 3'd4));

  // R9
  blc_in_readout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blc |-> (ssc && a_high));

  // R2
  cr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cr |-> (!a_high && !ssc && !vd));

  // R8
  vd_first_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vd |-> (a_high && line_idx == '0));

  // R7
  boost_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a_high) |-> (vd && !ssc));

endmodule

bind ccd_readout_seq ccd_readout_seq_chk #(.LINE_W(LINE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pix_stb  (pix_stb),
  .ssc      (ssc),
  .a_clk    (a_clk),
  .a_high   (a_high),
  .vd       (vd),
  .blc      (blc),
  .cr       (cr),
  .pix_tag  (pix_tag),
  .line_idx (line_idx)
);

// File: tb/sim_ccd_readout_seq.sv
module sim_ccd_readout_seq;

  localparam int DUMMY     = 2;
  localparam int BLACK     = 3;
  localparam int TIMING    = 1;
  localparam int ACTIVE    = 8;
  localparam int SLOT      = 2;
  localparam int BLK_LINES = 1;
  localparam int ACT_LINES = 3;
  localparam int CR_LEN    = 4;
  localparam int INTEG_W   = 8;
  localparam int LINES     = 2*BLK_LINES + ACT_LINES;
  localparam int LINE_W    = $clog2(LINES);
  localparam int PIX       = DUMMY + 2*BLACK + 2*TIMING + ACTIVE;
  localparam int VT        = 8 * SLOT;
  localparam int LINE_LEN  = VT + PIX;
  localparam int FRAME     = LINES * LINE_LEN;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start_frame = 1'b0;
  logic [INTEG_W-1:0] integ_time = '0;
  logic               pix_stb = 1'b0;
  logic               ssc;
  logic [3:0]         a_clk;
  logic               a_high;
  logic               vd;
  logic               blc;
  logic               cr;
  logic [2:0]         pix_tag;
  logic [LINE_W-1:0]  line_idx;

  int n_chk  = 0;
  int n_fail = 0;
  int cur_integ = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ccd_readout_seq #(
    .DUMMY(DUMMY), .BLACK(BLACK), .TIMING(TIMING), .ACTIVE(ACTIVE),
    .SLOT(SLOT), .BLK_LINES(BLK_LINES), .ACT_LINES(ACT_LINES),
    .CR_LEN(CR_LEN), .INTEG_W(INTEG_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start_frame(start_frame),
    .integ_time(integ_time), .pix_stb(pix_stb), .ssc(ssc), .a_clk(a_clk),
    .a_high(a_high), .vd(vd), .blc(blc), .cr(cr), .pix_tag(pix_tag),
    .line_idx(line_idx)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int kind_of(int h);
    if (h < DUMMY) return 1;
    if (h < DUMMY + BLACK) return 2;
    if (h < DUMMY + BLACK + TIMING) return 3;
    if (h < DUMMY + BLACK + TIMING + ACTIVE) return 4;
    if (h < DUMMY + BLACK + 2*TIMING + ACTIVE) return 3;
    return 2;
  endfunction

  function automatic int phase_code(int slot);
    int code = 0;
    for (int k = 0; k < 4; k++)
      if (((slot - 2*k + 8) % 8) < 5) code |= (1 << k);
    return code;
  endfunction

  // idx < 0 or past the frame means idle
  task automatic check_at(int idx, bit stb_now);
    int e_cr = 0, e_hi = 0, e_ssc = 0, e_a = 4'b1100, e_tag = 0;
    int e_blc = 0, e_vd = 0, e_line = 0;
    bit integ_ph = 1'b0;
    if (idx >= 0 && idx < CR_LEN) begin
      e_cr = 1;
    end else if (idx >= CR_LEN && idx < CR_LEN + cur_integ) begin
      integ_ph = 1'b1;
    end else if (idx >= 0 && idx < CR_LEN + cur_integ + FRAME) begin
      int r = idx - CR_LEN - cur_integ;
      int ln = r / LINE_LEN;
      int p = r % LINE_LEN;
      e_hi = 1;
      e_line = ln;
      e_vd = (ln == 0);
      if (p < VT) begin
        e_a = phase_code(p / SLOT);
      end else begin
        int h = p - VT;
        e_ssc = 1;
        e_blc = (h >= DUMMY && h < DUMMY + BLACK);
        e_tag = stb_now ? kind_of(h) : 0;
      end
    end
    if (idx < 0 || idx >= CR_LEN + cur_integ + FRAME) begin
      chk("R10 idle after frame a_high", int'(a_high), 0);
      chk("R10 idle after frame line_idx", int'(line_idx), 0);
    end
    if (integ_ph) begin
      chk("R3 integration cr", int'(cr), 0);
      chk("R3 integration a_high", int'(a_high), 0);
    end
    chk("R2 cr", int'(cr), e_cr);
    chk("R7 a_high", int'(a_high), e_hi);
    chk("R4 ssc", int'(ssc), e_ssc);
    chk("R6 a_clk", int'(a_clk), e_a);
    chk("R8 vd", int'(vd), e_vd);
    chk("R9 blc", int'(blc), e_blc);
    chk("R10 line_idx", int'(line_idx), e_line);
    if (stb_now) chk("R5 pix_tag", int'(pix_tag), e_tag);
    else         chk("R11 pix_tag without strobe", int'(pix_tag), 0);
  endtask

  task automatic run_frame(int integ, bit gaps);
    int total;
    cur_integ = integ;
    integ_time = INTEG_W'(integ);
    total = CR_LEN + integ + FRAME;
    start_frame = 1'b1;
    #1 check_at(-1, 1'b0);
    @(posedge clk); @(negedge clk);
    start_frame = 1'b0;
    for (int idx = 0; idx < total; idx++) begin
      int gap = gaps ? int'($urandom % 3) : 0;
      for (int g = 0; g < gap; g++) begin
        pix_stb = 1'b0;
        start_frame = ($urandom % 4 == 0);
        #1 check_at(idx, 1'b0);
        @(posedge clk); @(negedge clk);
      end
      pix_stb = 1'b1;
      start_frame = (idx < total - 1) && ($urandom % 5 == 0);
      #1 check_at(idx, 1'b1);
      @(posedge clk); @(negedge clk);
    end
    pix_stb = 1'b0;
    start_frame = 1'b0;
    #1 check_at(-1, 1'b0);
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    chk("R1 ssc", int'(ssc), 0);
    chk("R1 cr", int'(cr), 0);
    chk("R1 vd", int'(vd), 0);
    chk("R1 blc", int'(blc), 0);
    chk("R1 a_high", int'(a_high), 0);
    chk("R1 pix_tag", int'(pix_tag), 0);
    chk("R1 line_idx", int'(line_idx), 0);
    chk("R1 a_clk", int'(a_clk), 4'b1100);
    // R11 strobes alone do not leave idle
    pix_stb = 1'b1;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    pix_stb = 1'b0;
    #1 chk("R11 idle holds under strobes cr", int'(cr), 0);
    @(negedge clk);
    run_frame(0, 1'b0);   // R3 zero integration
    run_frame(1, 1'b1);   // R3 one strobe
    for (int f = 0; f < 3; f++) run_frame(int'($urandom % 20), 1'b1);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule